// File: doc/BRIEF.md
# Packet Bit Counter with Compare Event

This block counts the bits that pass through the serializer while a packet is on air and emits a one-cycle event when the running count reaches a programmable compare value. Counting is started by a start task, but only once the address stage of the current packet has completed. After a match the counter keeps running, so a new compare value can be loaded to produce further events inside the same packet.

A small state machine tracks three states. `ST_IDLE` means no address has been seen for this packet. `ST_ARMED` means the address has been seen and counting is possible. `ST_COUNT` means bits are being counted. The transitions are as follows. `ST_IDLE`→`ST_ARMED` happens on an address event. `ST_ARMED`→`ST_COUNT` happens on a start task. `ST_COUNT`→`ST_ARMED` happens on the counter stop task. Any state goes to `ST_IDLE` on the radio stop, end or disable task. The count register is 12 bits wide by default and saturates at its maximum value.

Top module: `pkt_bit_counter`

## Requirements
- R1: After reset `match_o` is low, the counter is stopped with a count of zero, and no address has been seen.
- R2: A start task is ignored unless an address event was seen in an earlier cycle since the last radio stop, end or disable task. An address event in the same cycle as the start does not qualify it.
- R3: While counting, each cycle with `bit_strb_i` high adds one to the count. Strobes while not counting, including the cycle of the start task itself, are not counted.
- R4: `match_o` is high for exactly one cycle, in the cycle right after the clock edge that captures the strobe which makes the count equal to `cmp_val_i`.
- R5: Counting continues past a match. A larger compare value written afterwards produces another match in the same packet.
- R6: The counter stop task (`cnt_stop_i`) halts counting and resets the count to zero. The address-seen condition is kept, so a new start is accepted without a new address event.
- R7: The radio stop, end and disable tasks each halt counting, reset the count to zero and clear the address-seen condition.
- R8: The count saturates at 4095 (all ones) and does not wrap to zero.
- R9: A compare value of zero never matches. A compare value that is left unchanged matches only once, and no further strobe produces a repeat match.
- R10: Any stop, end or disable task has priority over a bit strobe or start task in the same cycle. That strobe is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_evt_i | input | 1 | Address-received event pulse |
| cnt_start_i | input | 1 | Counter start task |
| cnt_stop_i | input | 1 | Counter stop task (keeps address-seen) |
| radio_stop_i | input | 1 | Radio stop task |
| radio_end_i | input | 1 | Radio end task |
| radio_disable_i | input | 1 | Radio disable task |
| bit_strb_i | input | 1 | One pulse per bit from the serializer |
| cmp_val_i | input | 12 | Compare value |
| match_o | output | 1 | One-cycle compare event |

## Verification
The situation hardest to reach from the ports is saturation. The count is not visible, so reaching it takes 4095 strobes inside one counting run with no stop task. Wrapping can only be seen as a later match on a small compare value. A directed run drives exactly that many strobes, then moves the compare value down to a small number and keeps strobing, expecting silence. Constrained random traffic with rare stop tasks covers the orderings of address, start, strobe and stop in the same cycle.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_COUNT = 2'd2
    } pbc_state_e;
endpackage

// File: rtl/pbc_fsm.sv
module pbc_fsm
    import pbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       addr_evt_i,
    input  logic       start_i,
    input  logic       cnt_stop_i,
    input  logic       clear_i,
    output pbc_state_e state_q,
    output logic       running_o,
    output logic       halt_o
);
    pbc_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!clear_i && addr_evt_i) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (clear_i)                     state_d = ST_IDLE;
                else if (start_i && !cnt_stop_i) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (clear_i)         state_d = ST_IDLE;
                else if (cnt_stop_i) state_d = ST_ARMED;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        running_o = (state_q == ST_COUNT);
        halt_o    = clear_i | cnt_stop_i;
    end
endmodule

// File: rtl/pbc_counter.sv
module pbc_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running_i,
    input  logic             halt_i,
    input  logic             strb_i,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next_o,
    output logic             inc_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_comb begin
        inc_o      = running_i && strb_i && !halt_i && (cnt_q != CNT_MAX);
        cnt_next_o = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (halt_i) cnt_q <= '0;
        else if (inc_o)  cnt_q <= cnt_next_o;
    end
endmodule

// File: rtl/pbc_match.sv
module pbc_match #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             match_o
);
    logic hit;

    always_comb hit = inc_i && (cnt_next_i == cmp_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) match_o <= 1'b0;
        else        match_o <= hit;
    end
endmodule

// File: rtl/pkt_bit_counter.sv
module pkt_bit_counter
    import pbc_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_evt_i,
    input  logic             cnt_start_i,
    input  logic             cnt_stop_i,
    input  logic             radio_stop_i,
    input  logic             radio_end_i,
    input  logic             radio_disable_i,
    input  logic             bit_strb_i,
    input  logic [CNT_W-1:0] cmp_val_i,
    output logic             match_o
);
    pbc_state_e       state_q;
    logic             running;
    logic             halt;
    logic             clear;
    logic             inc;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;

    always_comb clear = radio_stop_i | radio_end_i | radio_disable_i;

    pbc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_evt_i (addr_evt_i),
        .start_i    (cnt_start_i),
        .cnt_stop_i (cnt_stop_i),
        .clear_i    (clear),
        .state_q    (state_q),
        .running_o  (running),
        .halt_o     (halt)
    );

    pbc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .running_i  (running),
        .halt_i     (halt),
        .strb_i     (bit_strb_i),
        .cnt_q      (cnt_q),
        .cnt_next_o (cnt_next),
        .inc_o      (inc)
    );

    pbc_match #(.CNT_W(CNT_W)) u_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc_i      (inc),
        .cnt_next_i (cnt_next),
        .cmp_i      (cmp_val_i),
        .match_o    (match_o)
    );
endmodule

// File: rtl/pbc_checker.sv
module pbc_checker
    import pbc_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             addr_evt_i,
    input logic             cnt_start_i,
    input logic             cnt_stop_i,
    input logic             radio_stop_i,
    input logic             radio_end_i,
    input logic             radio_disable_i,
    input logic             bit_strb_i,
    input logic [CNT_W-1:0] cmp_val_i,
    input logic             match_o,
    input pbc_state_e       state_q,
    input logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic any_clear;
    always_comb any_clear = radio_stop_i | radio_end_i | radio_disable_i;

    a_r2_no_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> (state_q != ST_COUNT));

    a_r4_match_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> $past(bit_strb_i));

    a_r4_match_equals_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (cnt_q == $past(cmp_val_i)));

    a_r6_stop_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_stop_i |=> (cnt_q == '0 && state_q != ST_COUNT));

    a_r7_clear_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        any_clear |=> (state_q == ST_IDLE && cnt_q == '0));

    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !cnt_stop_i && !any_clear) |=> (cnt_q == CNT_MAX));

    a_r9_zero_never: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (cnt_q != '0));
endmodule

bind pkt_bit_counter pbc_checker #(.CNT_W(CNT_W)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .addr_evt_i      (addr_evt_i),
    .cnt_start_i     (cnt_start_i),
    .cnt_stop_i      (cnt_stop_i),
    .radio_stop_i    (radio_stop_i),
    .radio_end_i     (radio_end_i),
    .radio_disable_i (radio_disable_i),
    .bit_strb_i      (bit_strb_i),
    .cmp_val_i       (cmp_val_i),
    .match_o         (match_o),
    .state_q         (state_q),
    .cnt_q           (cnt_q)
);

// File: tb/pkt_bit_counter_tb.sv
module pkt_bit_counter_tb_top;
    localparam int CW = 12;
    localparam int MAXV = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ae = 0, st = 0, cs = 0, rs = 0, re = 0, rd = 0, sb = 0;
    logic [CW-1:0] cmp = '0;
    logic match_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit m_addr = 0;
    bit m_run  = 0;
    int m_cnt  = 0;

    always #5 clk = ~clk;

    pkt_bit_counter #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr_evt_i(ae), .cnt_start_i(st),
        .cnt_stop_i(cs), .radio_stop_i(rs), .radio_end_i(re),
        .radio_disable_i(rd), .bit_strb_i(sb), .cmp_val_i(cmp),
        .match_o(match_o)
    );

    function automatic bit exp_match(int cnt, bit run, bit halt, bit strb, int cv);
        bit inc;
        inc = run && strb && !halt && (cnt != MAXV);
        return inc && ((cnt + 1) == cv);
    endfunction

    task automatic check(string tag, bit act, bit expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s match_o actual=%0b expected=%0b", tag, act, expv);
        end
    endtask

    // apply current inputs for one edge, check, clear pulse inputs
    task automatic tick(string tag);
        bit clr, halt, em;
        clr  = rs | re | rd;
        halt = clr | cs;
        em   = exp_match(m_cnt, m_run, halt, sb, int'(cmp));
        @(posedge clk);
        @(negedge clk);
        check(tag, match_o, em);
        if (halt) m_cnt = 0;
        else if (m_run && sb && m_cnt != MAXV) m_cnt++;
        if (halt) m_run = 0;
        else if (st && m_addr) m_run = 1;
        if (clr) m_addr = 0;
        else if (ae) m_addr = 1;
        ae = 0; st = 0; cs = 0; rs = 0; re = 0; rd = 0; sb = 0;
    endtask

    task automatic strobes(int n, string tag);
        for (int i = 0; i < n; i++) begin
            sb = 1;
            tick(tag);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1 during reset", match_o, 1'b0);
        rst_n = 1;
        @(negedge clk);
        check("R1 after reset", match_o, 1'b0);

        // R2: start without address
        cmp = 12'd1;
        st = 1; tick("R2 start no addr");
        strobes(3, "R2 no count without addr");
        // R2: address and start same cycle
        ae = 1; st = 1; tick("R2 same-cycle addr");
        strobes(2, "R2 same-cycle start ignored");

        // R3/R4: start properly, start-cycle strobe not counted
        cmp = 12'd3;
        st = 1; sb = 1; tick("R3 start-cycle strobe");
        strobes(2, "R3 count 1..2");
        sb = 1; tick("R4 match at 3");
        tick("R4 single pulse");
        // R5: new compare value mid-packet
        cmp = 12'd5;
        strobes(2, "R5 second match");
        strobes(3, "R9 unchanged cmp no repeat");

        // R6: counter stop keeps address flag
        cs = 1; tick("R6 stop");
        cmp = 12'd2;
        st = 1; tick("R6 restart");
        strobes(2, "R6 count from zero");
        // R10: stop wins over strobe
        cs = 1; sb = 1; tick("R10 stop with strobe");
        st = 1; tick("R10 restart");
        cmp = 12'd1;
        strobes(1, "R10 count restarted at zero");

        // R7: radio end clears address flag
        re = 1; tick("R7 end");
        st = 1; tick("R7 start after end");
        strobes(2, "R7 ignored start");
        ae = 1; tick("R7 addr");
        st = 1; tick("R7 start");
        rd = 1; sb = 1; tick("R7 disable with strobe");
        strobes(2, "R7 halted by disable");
        ae = 1; tick("R7 addr2");
        st = 1; tick("R7 start2");
        rs = 1; tick("R7 radio stop");
        strobes(2, "R7 halted by stop");

        // R9: compare zero
        ae = 1; tick("R9 addr");
        st = 1; cmp = 12'd0; tick("R9 start");
        strobes(5, "R9 cmp zero");

        // R8: saturation
        cs = 1; tick("R8 reset count");
        st = 1; cmp = 12'(MAXV); tick("R8 start");
        strobes(MAXV, "R8 reach max");
        strobes(3, "R8 no repeat at max");
        cmp = 12'd4;
        strobes(10, "R8 no wrap");
        re = 1; tick("R8 end");

        // random traffic
        for (int i = 0; i < 6000; i++) begin
            ae  = ($urandom_range(0, 99) < 8);
            st  = ($urandom_range(0, 99) < 10);
            cs  = ($urandom_range(0, 99) < 2);
            rs  = ($urandom_range(0, 199) < 1);
            re  = ($urandom_range(0, 199) < 1);
            rd  = ($urandom_range(0, 199) < 1);
            sb  = ($urandom_range(0, 99) < 60);
            if ($urandom_range(0, 99) < 5) cmp = 12'($urandom_range(0, 40));
            tick("R4 random");
        end
        finish_run();
    end
endmodule